// File: doc/BRIEF.md
# Supervisory Shutdown and Reset Sequencer

This block is the digital decision core of a multi-rail power supervisor. It takes comparator flags for four monitored supply rails, a watchdog-fault flag with its mode select, a manual reset pin, a register-driven shutdown request and two hold-time codes. From these it drives two active-low lines: a shutdown line, used to disable downstream regulators, and a system reset line, used to hold a processor in reset. Both lines are low from power-up. Each one stays low until every cause feeding it has gone away and its own hold time has then run out.

Shutdown feeds the reset line, so any shutdown also resets the processor. The second rail is checked against a pair of thresholds. While the rail is coming up it must pass the higher turn-on level. Once it has qualified, it only faults when it drops below the lower turn-off level. A watchdog fault acts on shutdown only in the advanced watchdog mode. On the reset line it gives timed pulses, not a held level. Hold times are counted in ticks of a 1 kHz enable input. The analog comparators, the output drivers and the register interface lie outside the block and appear only as flag and register inputs.

Top module: `supv_seq_core`

## Requirements
- R1: After the synchronous reset is released, both `shdn_n` and `sys_rst_n` stay low. `shdn_n` rises only once its hold time has elapsed in full. `sys_rst_n` rises only once shutdown has released and the reset hold time has then elapsed in full.
- R2: When `rail1_over` or `rail1_under` is high, `shdn_n` goes low. It falls on the 4th rising clock edge after the flag changes, and it is still high after the 3rd edge.
- R3: The second rail starts out unqualified after reset. While unqualified, it causes shutdown until `rail2_above_on` is high. Once qualified, it causes shutdown only when `rail2_above_off` goes low. From then on it needs `rail2_above_on` again before it qualifies.
- R4: A `wd_fault` flag forces `shdn_n` low only when `wd_adv_mode` is 1. When `wd_adv_mode` is 0, `shdn_n` stays high while the flag is set.
- R5: `sw_shdn_req` (a synchronous register bit) forces `shdn_n` low 2 edges after it is sampled high. It is still high after 1 edge.
- R6: `rail3_low`, `rail4_low` or a low `man_rst_n` drives `sys_rst_n` low on the 4th edge after the change. None of them affects `shdn_n`.
- R7: Whenever `shdn_n` is low, `sys_rst_n` is low 2 edges later. `sys_rst_n` never rises unless `shdn_n` was high 2 edges earlier.
- R8: Hold codes 0, 1, 2 and 3 select `HOLD_T0`, `HOLD_T1`, `HOLD_T2` and `HOLD_T3` ticks (defaults 1, 10, 100 and 200 ms at a 1 kHz `tick_ms`). The count starts once all causes are gone. An output is low right after the edge that samples the last required tick, and it is high one edge later.
- R9: If a cause comes back while a hold is running, the hold count restarts from the full value.
- R10: A watchdog fault drives `sys_rst_n` low for a pulse of reset-hold-time ticks. If the fault is still set when the pulse ends, `sys_rst_n` goes high for exactly one clock cycle and a new pulse starts. A fault that is cleared lets the current pulse run to its end.
- R11: `drv_rail_sel` is a registered copy of `shdn_rail_sel`. 0 selects the first monitored rail as the shutdown driver rail and 1 selects the internal regulator. It follows one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low power-up reset |
| tick_ms | input | 1 | One-cycle hold-time enable, nominally 1 kHz, synchronous |
| rail1_over | input | 1 | First rail above its upper threshold (async) |
| rail1_under | input | 1 | First rail below its lower threshold (async) |
| rail2_above_on | input | 1 | Second rail above its turn-on threshold (async) |
| rail2_above_off | input | 1 | Second rail above its turn-off threshold (async) |
| rail3_low | input | 1 | Third rail below its threshold (async) |
| rail4_low | input | 1 | Fourth rail below its threshold (async) |
| wd_fault | input | 1 | Watchdog fault flag (async) |
| wd_adv_mode | input | 1 | 1: watchdog fault also causes shutdown (register) |
| man_rst_n | input | 1 | Manual reset, active low (async) |
| sw_shdn_req | input | 1 | Register-written shutdown request |
| shdn_hold_code | input | 2 | Shutdown hold-time code |
| rst_hold_code | input | 2 | Reset hold-time and watchdog-pulse code |
| shdn_rail_sel | input | 1 | Shutdown driver rail select register bit |
| shdn_n | output | 1 | Shutdown output, active low, registered |
| sys_rst_n | output | 1 | System reset output, active low, registered |
| drv_rail_sel | output | 1 | Registered rail select for the shutdown driver stage |

## Verification
Asynchronous flags go through a two-flop synchronizer, a hold timer and an output flop, so their effect on an output is due on the 4th edge. The second rail adds its qualification flop and is due on the 5th. A register request is due on the 2nd edge, and the chain from shutdown to reset adds 2 more edges. The bench drives every input just after a clock edge and samples just after the edge where a change is due. It also samples just after the edge before it, where the output must still be unchanged. Hold releases are checked one tick at a time: the output must be low right after the edge that samples the last tick and high after the next edge. The watchdog pulse train is sampled on every cycle, and the bench counts the single-cycle releases.

// File: rtl/supv_pkg.sv
// Shared types and helpers for the supervisory sequencer.
// Assumes hold codes are two bits wide and select one of four tick counts.
package supv_pkg;

    typedef enum logic [1:0] {
        HOLD_SHORT = 2'd0,
        HOLD_MED   = 2'd1,
        HOLD_LONG  = 2'd2,
        HOLD_MAX   = 2'd3
    } hold_code_e;

    // Map a hold code to its tick count.
    function automatic int unsigned pick_hold(
        input logic [1:0]  code,
        input int unsigned t0,
        input int unsigned t1,
        input int unsigned t2,
        input int unsigned t3
    );
        case (hold_code_e'(code))
            HOLD_SHORT: return t0;
            HOLD_MED:   return t1;
            HOLD_LONG:  return t2;
            default:    return t3;
        endcase
    endfunction

    // Larger of two counts, used to size counters.
    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/supv_sync_bank.sv
// Bank of two-flop synchronizers, one per bit.
// Assumes each bit is an independent level flag; RST_VAL gives the
// inactive level that each bit takes during reset.
module supv_sync_bank #(
    parameter int unsigned    W       = 8,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    generate
        for (genvar b = 0; b < W; b++) begin : g_bit
            logic meta_q;
            logic stab_q;

            // Two-stage capture of one asynchronous flag.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    meta_q <= RST_VAL[b];
                    stab_q <= RST_VAL[b];
                end else begin
                    meta_q <= async_i[b];
                    stab_q <= meta_q;
                end
            end

            assign sync_o[b] = stab_q;
        end
    endgenerate

endmodule

// File: rtl/supv_rail2_hyst.sv
// Qualification state for the second rail, which uses two thresholds.
// Unqualified: the rail needs the higher turn-on level to qualify.
// Qualified: it drops out only below the lower turn-off level.
// Assumes synchronized comparator inputs. The reset state is unqualified,
// so the rail counts as rising after power-up.
module supv_rail2_hyst (
    input  logic clk,
    input  logic rst_n,
    input  logic above_on,
    input  logic above_off,
    output logic fault
);

    logic ok_q;
    logic ok_d;

    // Pick the active threshold from the present qualification state.
    always_comb begin
        if (ok_q) ok_d = above_off;
        else      ok_d = above_on;
    end

    // Hold the qualification state.
    always_ff @(posedge clk) begin
        if (!rst_n) ok_q <= 1'b0;
        else        ok_q <= ok_d;
    end

    assign fault = !ok_q;

endmodule

// File: rtl/supv_hold_timer.sv
// Hold timer for one held output.
// While the cause is present the counter is reloaded with the full hold
// count. Once the cause is gone it counts down on each tick. The active
// flag is registered and is high while the count is non-zero.
// Assumes load_val >= 1 and that tick is a one-cycle synchronous enable.
module supv_hold_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             cause,
    input  logic [CNT_W-1:0] load_val,
    output logic             active
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    // Next count: reload on cause, otherwise step down on tick.
    always_comb begin
        cnt_d = cnt_q;
        if (cause)                           cnt_d = load_val;
        else if (tick && (cnt_q != '0))      cnt_d = cnt_q - 1'b1;
    end

    // Count register and registered busy flag (busy during reset).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            active <= 1'b1;
        end else begin
            cnt_q  <= cnt_d;
            active <= (cnt_d != '0);
        end
    end

endmodule

// File: rtl/supv_wd_pulser.sv
// Timed reset pulses for a watchdog fault.
// An idle pulser that sees the fault loads the pulse length. The count
// then drops on each tick whether or not the fault is still set. If the
// fault remains when the count reaches zero, a new pulse loads on the next
// cycle, which leaves exactly one idle cycle between pulses.
// Assumes len >= 1 and a synchronized fault flag.
module supv_wd_pulser #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             fault,
    input  logic [CNT_W-1:0] len,
    output logic             pulse
);

    logic [CNT_W-1:0] cnt_q;

    // Start a pulse when idle, otherwise time the running one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_q == '0) begin
            if (fault) cnt_q <= len;
        end else if (tick) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign pulse = (cnt_q != '0);

endmodule

// File: rtl/supv_seq_core.sv
// Supervisory shutdown and reset sequencer (top).
// Combines the rail, watchdog, manual and register causes into a held
// active-low shutdown line and a reset line. Shutdown chains into reset.
// A watchdog fault adds timed reset pulses, and in the advanced mode it
// also acts as a held shutdown cause.
// Assumes: asynchronous flags on the rail, watchdog and manual pins;
// register inputs and tick_ms already synchronous; HOLD_T* >= 1.
module supv_seq_core
    import supv_pkg::*;
#(
    parameter int unsigned HOLD_T0 = 1,
    parameter int unsigned HOLD_T1 = 10,
    parameter int unsigned HOLD_T2 = 100,
    parameter int unsigned HOLD_T3 = 200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_ms,
    input  logic       rail1_over,
    input  logic       rail1_under,
    input  logic       rail2_above_on,
    input  logic       rail2_above_off,
    input  logic       rail3_low,
    input  logic       rail4_low,
    input  logic       wd_fault,
    input  logic       wd_adv_mode,
    input  logic       man_rst_n,
    input  logic       sw_shdn_req,
    input  logic [1:0] shdn_hold_code,
    input  logic [1:0] rst_hold_code,
    input  logic       shdn_rail_sel,
    output logic       shdn_n,
    output logic       sys_rst_n,
    output logic       drv_rail_sel
);

    localparam int unsigned MAX_T  = max2(max2(HOLD_T0, HOLD_T1), max2(HOLD_T2, HOLD_T3));
    localparam int unsigned CNT_W  = $clog2(MAX_T + 1);
    localparam int unsigned N_SYNC = 8;
    // Bit order: man_rst_n, wd_fault, rail4, rail3, r2_off, r2_on, r1_under, r1_over
    localparam logic [N_SYNC-1:0] SYNC_RST = 8'b1000_0000;

    logic [N_SYNC-1:0] flags_async;
    logic [N_SYNC-1:0] flags_s;
    logic              r1_over_s, r1_under_s, r2_on_s, r2_off_s;
    logic              r3_low_s, r4_low_s, wd_s, mr_n_s;
    logic              por_q;
    logic              rail2_fault;
    logic              shdn_cause, rst_cause;
    logic              shdn_busy, rst_busy, wd_busy;
    logic [CNT_W-1:0]  shdn_len, rst_len;

    assign flags_async = {man_rst_n, wd_fault, rail4_low, rail3_low,
                          rail2_above_off, rail2_above_on, rail1_under, rail1_over};

    supv_sync_bank #(
        .W       (N_SYNC),
        .RST_VAL (SYNC_RST)
    ) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (flags_async),
        .sync_o  (flags_s)
    );

    assign {mr_n_s, wd_s, r4_low_s, r3_low_s, r2_off_s, r2_on_s, r1_under_s, r1_over_s} = flags_s;

    // One-cycle power-up cause that loads both hold timers after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) por_q <= 1'b1;
        else        por_q <= 1'b0;
    end

    supv_rail2_hyst rail2_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .above_on  (r2_on_s),
        .above_off (r2_off_s),
        .fault     (rail2_fault)
    );

    // Hold lengths selected by the register codes.
    always_comb begin
        shdn_len = CNT_W'(pick_hold(shdn_hold_code, HOLD_T0, HOLD_T1, HOLD_T2, HOLD_T3));
        rst_len  = CNT_W'(pick_hold(rst_hold_code,  HOLD_T0, HOLD_T1, HOLD_T2, HOLD_T3));
    end

    // Held causes for each output; reset also follows the shutdown line.
    always_comb begin
        shdn_cause = por_q | r1_over_s | r1_under_s | rail2_fault
                   | (wd_s & wd_adv_mode) | sw_shdn_req;
        rst_cause  = por_q | r3_low_s | r4_low_s | !mr_n_s | !shdn_n;
    end

    supv_hold_timer #(.CNT_W(CNT_W)) shdn_tmr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_ms),
        .cause    (shdn_cause),
        .load_val (shdn_len),
        .active   (shdn_busy)
    );

    supv_hold_timer #(.CNT_W(CNT_W)) rst_tmr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_ms),
        .cause    (rst_cause),
        .load_val (rst_len),
        .active   (rst_busy)
    );

    supv_wd_pulser #(.CNT_W(CNT_W)) wd_i (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick_ms),
        .fault (wd_s),
        .len   (rst_len),
        .pulse (wd_busy)
    );

    // Glitch-free registered outputs, all asserted during reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shdn_n       <= 1'b0;
            sys_rst_n    <= 1'b0;
            drv_rail_sel <= 1'b0;
        end else begin
            shdn_n       <= !shdn_busy;
            sys_rst_n    <= !(rst_busy | wd_busy);
            drv_rail_sel <= shdn_rail_sel;
        end
    end

endmodule

// File: rtl/supv_seq_core_chk.sv
// Port-level checker for supv_seq_core, bound to every instance.
// Assumes the synchronous active-low reset on rst_n.
module supv_seq_core_chk (
    input logic clk,
    input logic rst_n,
    input logic sw_shdn_req,
    input logic shdn_rail_sel,
    input logic shdn_n,
    input logic sys_rst_n,
    input logic drv_rail_sel
);

    // A register shutdown request lands on the line two edges later.
    assert_req_forces_shdn_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sw_shdn_req |-> ##2 !shdn_n);

    // Shutdown always pulls reset low two edges later.
    assert_shdn_chains_rst_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !shdn_n |-> ##2 !sys_rst_n);

    // Reset only releases when shutdown was already released.
    assert_rst_waits_shdn_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_n) |-> $past(shdn_n, 2));

    // Shutdown never releases while a request was pending.
    assert_no_release_on_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shdn_n) |-> !$past(sw_shdn_req, 2));

    // Driver rail select follows its register bit by one edge.
    assert_rail_sel_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (drv_rail_sel == $past(shdn_rail_sel)));

endmodule

bind supv_seq_core supv_seq_core_chk chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .sw_shdn_req   (sw_shdn_req),
    .shdn_rail_sel (shdn_rail_sel),
    .shdn_n        (shdn_n),
    .sys_rst_n     (sys_rst_n),
    .drv_rail_sel  (drv_rail_sel)
);

// File: tb/supv_seq_core_tb_top.sv
// Self-checking bench for supv_seq_core with short hold counts.
// Sweeps every hold code, every rail-1 and rail-3/4/manual combination,
// both watchdog modes and the second-rail threshold states.
module supv_seq_core_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int T0 = 1, T1 = 2, T2 = 3, T3 = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_ms = 1'b0;
    logic       rail1_over = 1'b0, rail1_under = 1'b0;
    logic       rail2_above_on = 1'b1, rail2_above_off = 1'b1;
    logic       rail3_low = 1'b0, rail4_low = 1'b0;
    logic       wd_fault = 1'b0, wd_adv_mode = 1'b0;
    logic       man_rst_n = 1'b1, sw_shdn_req = 1'b0;
    logic [1:0] shdn_hold_code = 2'd2, rst_hold_code = 2'd1;
    logic       shdn_rail_sel = 1'b0;
    logic       shdn_n, sys_rst_n, drv_rail_sel;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    supv_seq_core #(
        .HOLD_T0(T0), .HOLD_T1(T1), .HOLD_T2(T2), .HOLD_T3(T3)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms),
        .rail1_over(rail1_over), .rail1_under(rail1_under),
        .rail2_above_on(rail2_above_on), .rail2_above_off(rail2_above_off),
        .rail3_low(rail3_low), .rail4_low(rail4_low),
        .wd_fault(wd_fault), .wd_adv_mode(wd_adv_mode),
        .man_rst_n(man_rst_n), .sw_shdn_req(sw_shdn_req),
        .shdn_hold_code(shdn_hold_code), .rst_hold_code(rst_hold_code),
        .shdn_rail_sel(shdn_rail_sel),
        .shdn_n(shdn_n), .sys_rst_n(sys_rst_n), .drv_rail_sel(drv_rail_sel)
    );

    function automatic int ticks_of(input logic [1:0] c);
        case (c)
            2'd0: return T0;
            2'd1: return T1;
            2'd2: return T2;
            default: return T3;
        endcase
    endfunction

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", what, act, exp);
        end
    endtask

    function automatic logic outv(input int which);
        return (which == 0) ? shdn_n : sys_rst_n;
    endfunction

    // Causes already removed: wait out the sync path, then tick to release.
    task automatic release_out(input int which, input int n, input string tag);
        step(6);
        for (int k = 0; k < n; k++) begin
            tick_ms = 1'b1; step(1); tick_ms = 1'b0;
            check(outv(which), 1'b0, {tag, " low until last tick"});
            if (k < n - 1) step(2);
        end
        step(1);
        check(outv(which), 1'b1, {tag, " released after last tick"});
    endtask

    task automatic recover(input string tag);
        release_out(0, ticks_of(shdn_hold_code), {tag, " shdn"});
        release_out(1, ticks_of(rst_hold_code), {tag, " rst"});
    endtask

    // Tick n times while sampling every cycle.
    task automatic wd_window(input int n, output int highs, output int shdn_lows);
        highs = 0; shdn_lows = 0;
        for (int k = 0; k < n; k++) begin
            tick_ms = 1'b1; step(1); tick_ms = 1'b0;
            if (sys_rst_n) highs++;
            if (!shdn_n) shdn_lows++;
            for (int j = 0; j < 3; j++) begin
                step(1);
                if (sys_rst_n) highs++;
                if (!shdn_n) shdn_lows++;
            end
        end
    endtask

    task automatic run_tests();
        int highs, slows;
        // R1: reset state and power-up hold
        step(3);
        check(shdn_n, 1'b0, "R1 shdn low in reset");
        check(sys_rst_n, 1'b0, "R1 rst low in reset");
        rst_n = 1'b1;
        step(8);
        check(shdn_n, 1'b0, "R1 shdn low before hold");
        check(sys_rst_n, 1'b0, "R1 rst low before hold");
        recover("R1 power-up");

        // R11: rail select copy
        shdn_rail_sel = 1'b1; step(1);
        check(drv_rail_sel, 1'b1, "R11 select regulator");
        shdn_rail_sel = 1'b0; step(1);
        check(drv_rail_sel, 1'b0, "R11 select rail1");

        // R2: every rail-1 fault combination
        for (int v = 1; v < 4; v++) begin
            rail1_over = v[0]; rail1_under = v[1];
            step(3); check(shdn_n, 1'b1, "R2 shdn not yet");
            step(1); check(shdn_n, 1'b0, "R2 shdn on rail1 fault");
            rail1_over = 1'b0; rail1_under = 1'b0;
            recover("R2");
        end

        // R5, R7: request latency and chain into reset
        sw_shdn_req = 1'b1; step(1); sw_shdn_req = 1'b0;
        check(shdn_n, 1'b1, "R5 shdn after 1 edge");
        step(1); check(shdn_n, 1'b0, "R5 shdn after 2 edges");
        step(1); check(sys_rst_n, 1'b1, "R7 rst not yet");
        step(1); check(sys_rst_n, 1'b0, "R7 rst follows shdn");
        recover("R7");

        // R8: sweep shutdown hold codes
        for (int c = 0; c < 4; c++) begin
            shdn_hold_code = 2'(c);
            sw_shdn_req = 1'b1; step(1); sw_shdn_req = 1'b0;
            release_out(0, ticks_of(2'(c)), "R8 shdn code");
            release_out(1, ticks_of(rst_hold_code), "R8 chained rst");
        end

        // R6, R8: every rail3/rail4/manual combination, all reset codes
        for (int v = 1; v < 8; v++) begin
            rst_hold_code = 2'(v % 4);
            rail3_low = v[0]; rail4_low = v[1]; man_rst_n = !v[2];
            step(3); check(sys_rst_n, 1'b1, "R6 rst not yet");
            step(1); check(sys_rst_n, 1'b0, "R6 rst on rail3/4/manual");
            check(shdn_n, 1'b1, "R6 shdn unaffected");
            rail3_low = 1'b0; rail4_low = 1'b0; man_rst_n = 1'b1;
            release_out(1, ticks_of(rst_hold_code), "R8 rst code");
        end
        shdn_hold_code = 2'd2; rst_hold_code = 2'd1;

        // R3: second rail thresholds
        rail2_above_on = 1'b0; step(6);
        check(shdn_n, 1'b1, "R3 between thresholds while qualified");
        rail2_above_off = 1'b0; step(6);
        check(shdn_n, 1'b0, "R3 below turn-off");
        rail2_above_off = 1'b1; step(6);
        check(shdn_n, 1'b0, "R3 between thresholds while rising");
        rail2_above_on = 1'b1;
        recover("R3");

        // R9: hold restarts when the cause returns
        shdn_hold_code = 2'd3;
        sw_shdn_req = 1'b1; step(1); sw_shdn_req = 1'b0; step(6);
        for (int k = 0; k < 3; k++) begin
            tick_ms = 1'b1; step(1); tick_ms = 1'b0; step(2);
        end
        sw_shdn_req = 1'b1; step(1); sw_shdn_req = 1'b0;
        release_out(0, T3, "R9 restart full hold");
        release_out(1, ticks_of(rst_hold_code), "R9 rst");
        shdn_hold_code = 2'd2;

        // R4, R10: watchdog in basic mode
        wd_adv_mode = 1'b0; wd_fault = 1'b1;
        step(4);
        check(sys_rst_n, 1'b0, "R10 wd pulse starts");
        check(shdn_n, 1'b1, "R4 basic mode no shdn");
        wd_window(2 * ticks_of(rst_hold_code), highs, slows);
        check(highs == 2, 1'b1, "R10 two one-cycle releases");
        check(slows == 0, 1'b1, "R4 shdn stayed high");
        wd_fault = 1'b0;
        release_out(1, ticks_of(rst_hold_code), "R10 last pulse ends");

        // R4: watchdog in advanced mode
        wd_adv_mode = 1'b1; wd_fault = 1'b1;
        step(4);
        check(shdn_n, 1'b0, "R4 advanced mode shdn");
        wd_fault = 1'b0;
        recover("R4");
    endtask

    initial begin
        fork
            run_tests();
            begin
                repeat (100000) @(posedge clk);
                errors++;
                $display("FAIL watchdog expired (all requirements) actual=timeout expected=done");
            end
        join_any
        disable fork;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule